// File: doc/BRIEF.md
# Event Ring Producer

This block is the device-side writer of a circular event ring that lives in host memory. Upstream sources (transfer completion, command completion and state-change logic) offer one event at a time on a valid/ready handshake. For every accepted event the block issues a single memory write of the event descriptor into the slot named by its local read pointer. After that write is acknowledged, it moves the read pointer on by one slot and pulses an interrupt towards the host.

The host hands consumed slots back by writing a new value of the write pointer. Both pointers are kept locally. The ring uses a reversed convention: it counts as full when the two pointers are equal. It counts as empty when the slot after the write pointer is the read pointer. The ring length can be programmed, and both pointers wrap from the last slot back to slot 0. When the ring is full, the block withholds ready rather than overwrite a slot that has not been consumed.

Top module: `evring_producer`

## Requirements
- R1: When reset is held low, the block takes read pointer 1 and write pointer 0. After reset, `ev_ready_o` is 1, `wr_req_o` is 0, `irq_o` is 0 and `ring_empty_o` is 1.
- R2: An event is accepted on a clock edge where valid and ready are both high. From the next cycle, `wr_req_o` is 1 and `wr_slot_o` equals the read pointer. `wr_data_o` is `{ev_kind_i, ev_info_i}` with the kind in the top two bits, coded as 00 transfer done, 01 command done, 10 state change. The request and its slot and data hold steady until `wr_ack_i` is seen.
- R3: `ev_ready_o` is 0 while a descriptor write is outstanding, so only one event is in flight at a time.
- R4: On the edge where the outstanding write is acknowledged, the read pointer advances by one. It wraps from `ring_len_i - 1` to 0. At no other time does it change, except at reset.
- R5: `irq_o` is high for exactly one cycle, the cycle after the acknowledged write. It is never high at any other time.
- R6: When the read pointer equals the write pointer (ring full), `ev_ready_o` is 0 and no write request starts, whatever `ev_valid_i` does.
- R7: When `host_wp_we_i` is high at a clock edge, the local write pointer takes `host_wp_i`. If this makes room in a full ring, `ev_ready_o` returns in the following cycle.
- R8: `ring_empty_o` is 1 exactly when the write pointer, advanced by one with wrap, equals the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_len_i | input | PTR_W+1 | Number of ring slots, 2 to 2^PTR_W |
| host_wp_i | input | PTR_W | New write pointer from the host |
| host_wp_we_i | input | 1 | Load strobe for `host_wp_i` |
| ev_valid_i | input | 1 | Event offered by a source |
| ev_kind_i | input | 2 | Event kind code |
| ev_info_i | input | INFO_W | Event-specific content |
| ev_ready_o | output | 1 | Block can accept an event |
| wr_req_o | output | 1 | Descriptor write request |
| wr_slot_o | output | PTR_W | Ring slot index to write |
| wr_data_o | output | INFO_W+2 | Descriptor contents |
| wr_ack_i | input | 1 | Memory write accepted |
| irq_o | output | 1 | One-cycle interrupt pulse |
| rp_o | output | PTR_W | Local read pointer |
| ring_empty_o | output | 1 | Ring holds no unserviced events |

## Verification
The write request, with its slot and data, is due one cycle after the accepting edge. The advanced read pointer and the interrupt pulse are due one cycle after the acknowledging edge, and the pulse must be gone one cycle later. Ready and the empty flag follow a host pointer load one cycle after its edge. The bench drives inputs and samples outputs at the falling edge, counting exactly those cycles in each case. Each ack delay and each expected slot comes from the stimulus table, so the slot sequence across a wrap is fixed ahead of time rather than read back from the design.

// File: rtl/evring_pkg.sv
// Shared types for the event ring producer.
// Assumes: kind codes are decoded by host software and must stay fixed.
package evring_pkg;

    // Event kind codes carried in the top two descriptor bits
    typedef enum logic [1:0] {
        EVK_XFER_DONE = 2'b00,
        EVK_CMD_DONE  = 2'b01,
        EVK_STATE_CHG = 2'b10,
        EVK_SPARE     = 2'b11
    } ev_kind_e;

    // Posting sequencer states
    typedef enum logic {
        PST_IDLE  = 1'b0,
        PST_WRITE = 1'b1
    } post_state_e;

endpackage

// File: rtl/evring_ptr.sv
// Local read/write pointer pair for the event ring.
// Read pointer: the next slot the device fills. Write pointer: the host's
// return mark. Full when equal; empty when wrap(wp + 1) equals rp.
// Assumes ring_len_i is in 2..2^PTR_W and host values are below ring_len_i.
module evring_ptr #(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W:0]   ring_len_i,
    input  logic [PTR_W-1:0] host_wp_i,
    input  logic             host_wp_we_i,
    input  logic             advance_i,
    output logic [PTR_W-1:0] rp_o,
    output logic             full_o,
    output logic             empty_o
);

    localparam logic [PTR_W:0] ONE_W = (PTR_W+1)'(1);

    logic [PTR_W-1:0] rp_q;
    logic [PTR_W-1:0] wp_q;
    logic [PTR_W-1:0] rp_step;
    logic [PTR_W-1:0] wp_step;

    // Advance a pointer by one slot, wrapping at the programmed length
    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p,
                                                  input logic [PTR_W:0]   len);
        if ({1'b0, p} == len - ONE_W) return '0;
        return p + 1'b1;
    endfunction

    // Next-slot values for both pointers
    always_comb begin
        rp_step = wrap_inc(rp_q, ring_len_i);
        wp_step = wrap_inc(wp_q, ring_len_i);
    end

    // Read pointer: moves only when a descriptor write completes
    always_ff @(posedge clk) begin
        if (!rst_n)         rp_q <= PTR_W'(1);
        else if (advance_i) rp_q <= rp_step;
    end

    // Write pointer: loaded by the host when it returns slots
    always_ff @(posedge clk) begin
        if (!rst_n)            wp_q <= '0;
        else if (host_wp_we_i) wp_q <= host_wp_i;
    end

    assign rp_o    = rp_q;
    assign full_o  = (rp_q == wp_q);
    assign empty_o = (wp_step == rp_q);

    // R6: a full ring never sees a completed post
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !advance_i);

    // R4: read pointer is frozen when no write completes
    p_rp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !advance_i |=> $stable(rp_q));

    // R8: full and empty cannot both hold for a ring of two or more slots
    p_full_empty_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));

endmodule

// File: rtl/evring_post.sv
// Posting sequencer: accepts one event, holds its descriptor on the memory
// write request until acknowledged, then reports the advance and pulses
// the interrupt register for one cycle.
// Assumes the memory side keeps wr_ack_i low while no request is raised.
module evring_post
    import evring_pkg::*;
#(
    parameter int DESC_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid_i,
    input  logic [DESC_W-1:0] ev_desc_i,
    input  logic              full_i,
    output logic              ev_ready_o,
    output logic              wr_req_o,
    output logic [DESC_W-1:0] wr_data_o,
    input  logic              wr_ack_i,
    output logic              advance_o,
    output logic              irq_o
);

    post_state_e       state_q;
    logic [DESC_W-1:0] desc_q;
    logic              irq_q;
    logic              accept;

    // Handshake decode
    always_comb begin
        ev_ready_o = (state_q == PST_IDLE) && !full_i;
        accept     = ev_valid_i && ev_ready_o;
        advance_o  = (state_q == PST_WRITE) && wr_ack_i;
    end

    // State: idle until an event is taken, write until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n)         state_q <= PST_IDLE;
        else if (accept)    state_q <= PST_WRITE;
        else if (advance_o) state_q <= PST_IDLE;
    end

    // Descriptor capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n)      desc_q <= '0;
        else if (accept) desc_q <= ev_desc_i;
    end

    // Interrupt register: one pulse per acknowledged descriptor
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= advance_o;
    end

    assign wr_req_o  = (state_q == PST_WRITE);
    assign wr_data_o = desc_q;
    assign irq_o     = irq_q;

    // R2: unacknowledged request keeps request and data
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_data_o)));

    // R3: nothing accepted while a write is outstanding
    p_busy_no_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> !ev_ready_o);

    // R5: interrupt follows an acknowledged write
    p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(wr_req_o && wr_ack_i));

    // R5: interrupt lasts a single cycle
    p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

endmodule

// File: rtl/evring_producer.sv
// Event ring producer top: joins the pointer pair and the posting
// sequencer. Descriptor layout is {kind[1:0], info}. The write slot is
// the live read pointer, which cannot move while a write is open.
module evring_producer
    import evring_pkg::*;
#(
    parameter int PTR_W  = 4,
    parameter int INFO_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PTR_W:0]      ring_len_i,
    input  logic [PTR_W-1:0]    host_wp_i,
    input  logic                host_wp_we_i,
    input  logic                ev_valid_i,
    input  logic [1:0]          ev_kind_i,
    input  logic [INFO_W-1:0]   ev_info_i,
    output logic                ev_ready_o,
    output logic                wr_req_o,
    output logic [PTR_W-1:0]    wr_slot_o,
    output logic [INFO_W+1:0]   wr_data_o,
    input  logic                wr_ack_i,
    output logic                irq_o,
    output logic [PTR_W-1:0]    rp_o,
    output logic                ring_empty_o
);

    localparam int DESC_W = INFO_W + 2;

    logic             full;
    logic             advance;
    logic [PTR_W-1:0] rp;

    evring_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk          (clk),
        .rst_n        (rst_n),
        .ring_len_i   (ring_len_i),
        .host_wp_i    (host_wp_i),
        .host_wp_we_i (host_wp_we_i),
        .advance_i    (advance),
        .rp_o         (rp),
        .full_o       (full),
        .empty_o      (ring_empty_o)
    );

    evring_post #(.DESC_W(DESC_W)) u_post (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_valid_i (ev_valid_i),
        .ev_desc_i  ({ev_kind_i, ev_info_i}),
        .full_i     (full),
        .ev_ready_o (ev_ready_o),
        .wr_req_o   (wr_req_o),
        .wr_data_o  (wr_data_o),
        .wr_ack_i   (wr_ack_i),
        .advance_o  (advance),
        .irq_o      (irq_o)
    );

    assign wr_slot_o = rp;
    assign rp_o      = rp;

    // R2: slot index is steady for the whole life of a request
    p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_ack_i) |=> $stable(wr_slot_o));

endmodule

// File: tb/evring_producer_bench.sv
module evring_producer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PTR_W  = 4;
    localparam int INFO_W = 24;
    localparam int DW     = INFO_W + 2;
    localparam int NVEC   = 8;

    // {kind[1:0], info[23:0], ack_delay[2:0], expected_slot[3:0]}, ring length 4
    localparam logic [32:0] VEC [0:NVEC-1] = '{
        {2'b00, 24'hA00001, 3'd0, 4'd1},
        {2'b01, 24'hB00002, 3'd2, 4'd2},
        {2'b10, 24'hC00003, 3'd1, 4'd3},
        {2'b00, 24'h5A5A5A, 3'd0, 4'd0},
        {2'b01, 24'hFFFFFF, 3'd3, 4'd1},
        {2'b10, 24'h000000, 3'd0, 4'd2},
        {2'b00, 24'h123456, 3'd4, 4'd3},
        {2'b01, 24'h654321, 3'd1, 4'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PTR_W:0]    ring_len = 5'd4;
    logic [PTR_W-1:0]  host_wp = '0;
    logic              host_wp_we = 1'b0;
    logic              ev_valid = 1'b0;
    logic [1:0]        ev_kind = '0;
    logic [INFO_W-1:0] ev_info = '0;
    logic              ev_ready;
    logic              wr_req;
    logic [PTR_W-1:0]  wr_slot;
    logic [DW-1:0]     wr_data;
    logic              wr_ack = 1'b0;
    logic              irq;
    logic [PTR_W-1:0]  rp;
    logic              ring_empty;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evring_producer #(.PTR_W(PTR_W), .INFO_W(INFO_W)) u_evring_producer (
        .clk          (clk),
        .rst_n        (rst_n),
        .ring_len_i   (ring_len),
        .host_wp_i    (host_wp),
        .host_wp_we_i (host_wp_we),
        .ev_valid_i   (ev_valid),
        .ev_kind_i    (ev_kind),
        .ev_info_i    (ev_info),
        .ev_ready_o   (ev_ready),
        .wr_req_o     (wr_req),
        .wr_slot_o    (wr_slot),
        .wr_data_o    (wr_data),
        .wr_ack_i     (wr_ack),
        .irq_o        (irq),
        .rp_o         (rp),
        .ring_empty_o (ring_empty)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return ({1'b0, p} == ring_len - 1) ? '0 : p + 1'b1;
    endfunction

    // Apply reset and check the idle state (R1)
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(rp, 1, "R1 rp");
        chk(ev_ready, 1, "R1 ready");
        chk(wr_req, 0, "R1 wr_req");
        chk(irq, 0, "R1 irq");
        chk(ring_empty, 1, "R1 empty");
    endtask

    // Host returns slots by loading the write pointer (R7)
    task automatic host_load(input logic [PTR_W-1:0] v);
        host_wp = v;
        host_wp_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        host_wp_we = 1'b0;
    endtask

    // Post one event and follow it to its interrupt (R2..R5)
    task automatic post(input logic [1:0] k, input logic [INFO_W-1:0] inf,
                        input int dly, input logic [PTR_W-1:0] slot);
        ev_valid = 1'b1; ev_kind = k; ev_info = inf;
        #1;
        chk(ev_ready, 1, "R6 ready when not full");
        @(posedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        #1;
        chk(wr_req, 1, "R2 request");
        chk(wr_slot, slot, "R2 slot");
        chk(wr_data, {k, inf}, "R2 data");
        chk(ev_ready, 0, "R3 busy");
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            #1;
            chk({wr_req, wr_slot}, {1'b1, slot}, "R2 held");
            chk(wr_data, {k, inf}, "R2 data held");
            chk(irq, 0, "R5 no early irq");
            chk(rp, slot, "R4 rp frozen");
        end
        wr_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_ack = 1'b0;
        #1;
        chk(irq, 1, "R5 irq pulse");
        chk(rp, nxt(slot), "R4 rp advance");
        chk(wr_req, 0, "R2 request dropped");
        @(negedge clk);
        #1;
        chk(irq, 0, "R5 single cycle");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();

        // Table walk: each event is consumed at once by the host
        for (int v = 0; v < NVEC; v++) begin
            post(VEC[v][32:31], VEC[v][30:7], int'(VEC[v][6:4]), VEC[v][3:0]);
            #1;
            chk(ring_empty, 0, "R8 not empty after post");
            host_load(VEC[v][3:0]);
            #1;
            chk(ring_empty, 1, "R8 empty after host return");
        end

        // Fill the ring (rp=1, wp=0, length 4: three posts)
        post(2'b10, 24'h000111, 0, 4'd1);
        post(2'b00, 24'h000222, 1, 4'd2);
        post(2'b01, 24'h000333, 0, 4'd3);
        ev_valid = 1'b1; ev_kind = 2'b00; ev_info = 24'hDEAD00;
        for (int i = 0; i < 4; i++) begin
            #1;
            chk(ev_ready, 0, "R6 full blocks ready");
            chk(wr_req, 0, "R6 no request when full");
            chk(rp, 0, "R6 rp held when full");
            @(negedge clk);
        end
        ev_valid = 1'b0;

        // Host frees two slots: ready returns next cycle (R7)
        host_load(4'd2);
        #1;
        chk(ev_ready, 1, "R7 ready after host frees");
        chk(ring_empty, 0, "R8 not empty with pending events");
        post(2'b10, 24'hBEEF01, 0, 4'd0);

        // Short ring of three slots: wrap from 2 to 0 (R4)
        ring_len = 5'd3;
        do_reset();
        post(2'b00, 24'h300001, 0, 4'd1);
        host_load(4'd1);
        post(2'b01, 24'h300002, 2, 4'd2);
        #1;
        chk(rp, 0, "R4 wrap at length 3");
        host_load(4'd2);
        #1;
        chk(ring_empty, 1, "R8 empty across wrap");
        post(2'b10, 24'h300003, 0, 4'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule